// File: doc/BRIEF.md
# Dual-Channel Power-Good Supervisor

This block combines the status of two switching regulator channels into one power-good flag. Each channel supplies three flags: an enable, a flag that its soft-start ramp has completed, and a flag from an external comparator saying its output sits inside the ±7.5% window around target. A supply-undervoltage flag is also taken in. The block runs on the regulator's oscillator clock. Its active-high output drives an open-drain power-good pin outside the block.

The flag rises only after a long qualified delay, and it falls at once. Every enabled channel must have completed soft-start and held its window for DELAY consecutive clocks (2048 by default) before the flag goes high. A window excursion on a monitored channel, or supply undervoltage, pulls it low on the next clock. Turning one channel off leaves the flag as it is, and the supervisor then watches only the remaining channel. A channel that is switched on late is handled in one of two ways. If the flag is still low, the delay count waits for that channel and restarts from zero. If the flag is already high, the channel is ignored until its own soft-start finishes. All inputs pass through a SYNC_STAGES-deep flop synchronizer (2 by default) before use.

Top module: `pgood_supervisor`

## Requirements
- R1: During reset the output is 0. It is 0 after reset and whenever both enables are low, falling SYNC_STAGES+1 clock edges after the second enable goes low.
- R2: The output rises on the (DELAY+SYNC_STAGES)-th rising edge after the last input change that leaves every enabled channel soft-start-complete and in window, with undervoltage clear, and not before.
- R3: While any enabled channel has not finished soft-start, and the output is low, the output stays low however long its window flag is high.
- R4: Any clock in which the qualification of R2 is lost clears the delay count. The full DELAY-clock count then restarts, even after a single-cycle interruption.
- R5: While the output is high, an enabled channel with soft-start complete and its window flag low drives the output to 0 on the SYNC_STAGES+1-th edge after the window flag falls.
- R6: Supply undervoltage drives the output to 0 with the same SYNC_STAGES+1-edge latency.
- R7: Disabling one channel while the other remains qualified leaves the output unchanged. The disabled channel's soft-start and window flags then have no effect.
- R8: After one channel is disabled, the output falls and rises again according to the remaining channel alone.
- R9: A channel enabled while the output is high is ignored until its soft-start flag rises. From then on its window flag can drop the output.
- R10: A channel enabled while the output is low and the delay count is running holds the output low. The DELAY-clock count restarts once that channel finishes soft-start.
- R11: The delay count saturates at its terminal value. The output stays high for as long as the inputs stay qualified (checked over more than 2×DELAY clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | N_CH | Per-channel enable, bit i = channel i |
| ch_ss_done | input | N_CH | Per-channel soft-start-complete flag |
| ch_in_win | input | N_CH | Per-channel in-regulation window flag |
| supply_uv | input | 1 | Supply undervoltage flag, active high |
| pgood | output | 1 | Combined power-good, active high |

## Verification
With the default two synchronizer stages, a falling result is due on the third rising edge after the bench changes an input, and a rising result on edge DELAY+2. The bench drives inputs on falling edges. A driver task turns each stimulus into absolute cycle numbers for the moment just before and just after the expected change, and queues them. A monitor counts rising edges and compares the output on each falling edge that matches the head of the queue. Holding checks for R3, R7, R9 and R10 are placed well past the cycle where a faulty design would have risen or fallen.

// File: rtl/pg_sup_pkg.sv
package pg_sup_pkg;
   localparam int unsigned PG_DELAY_DEF = 2048;
   localparam int unsigned PG_SYNC_DEF  = 2;

   // counter width able to hold the value 'limit'
   function automatic int unsigned cnt_bits(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/pg_sup_sync.sv
module pg_sup_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe <= '0;
            end else begin
               pipe[0] <= d;
               for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pg_sup_qual.sv
module pg_sup_qual #(
   parameter int unsigned N_CH = 2
) (
   input  logic [N_CH-1:0] en,
   input  logic [N_CH-1:0] ss,
   input  logic [N_CH-1:0] win,
   input  logic            uv,
   output logic            ok,
   output logic            drop
);
   logic [N_CH-1:0] blocking;  // enabled but not yet ready to count
   logic [N_CH-1:0] faulted;   // enabled, ramp done, out of window

   generate
      for (genvar i = 0; i < N_CH; i++) begin : g_ch
         assign blocking[i] = en[i] & ~(ss[i] & win[i]);
         assign faulted[i]  = en[i] & ss[i] & ~win[i];
      end
   endgenerate

   assign ok   = (|en) & ~uv & ~(|blocking);
   assign drop = uv | ~(|en) | (|faulted);
endmodule

// File: rtl/pg_sup_dly.sv
module pg_sup_dly #(
   parameter int unsigned DELAY = pg_sup_pkg::PG_DELAY_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ok,
   output logic ready
);
   localparam int unsigned CNT_W = pg_sup_pkg::cnt_bits(DELAY);
   localparam logic [CNT_W-1:0] TERM = CNT_W'(DELAY);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!ok)        cnt <= '0;
      else if (cnt != TERM) cnt <= cnt + 1'b1;
   end

   assign ready = ok & (cnt >= LAST);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TERM);                                     // R11
   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !ok |=> (cnt == '0));                             // R4
endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor #(
   parameter int unsigned N_CH        = 2,
   parameter int unsigned DELAY       = pg_sup_pkg::PG_DELAY_DEF,
   parameter int unsigned SYNC_STAGES = pg_sup_pkg::PG_SYNC_DEF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] ch_en,
   input  logic [N_CH-1:0] ch_ss_done,
   input  logic [N_CH-1:0] ch_in_win,
   input  logic            supply_uv,
   output logic            pgood
);
   localparam int unsigned BUS_W = 3 * N_CH + 1;

   generate
      if (N_CH < 1) begin : g_bad_nch
         $error("pgood_supervisor: N_CH must be at least 1");
      end
      if (DELAY < 2) begin : g_bad_delay
         $error("pgood_supervisor: DELAY must be at least 2");
      end
      if (SYNC_STAGES > 8) begin : g_bad_sync
         $error("pgood_supervisor: SYNC_STAGES above 8 is not supported");
      end
   endgenerate

   logic [BUS_W-1:0] raw_bus, sync_bus;
   logic [N_CH-1:0]  en_s, ss_s, win_s;
   logic             uv_s;
   logic             ok, drop, ready;
   logic             pgood_q;

   assign raw_bus = {supply_uv, ch_in_win, ch_ss_done, ch_en};

   pg_sup_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
   );

   assign en_s  = sync_bus[N_CH-1:0];
   assign ss_s  = sync_bus[2*N_CH-1:N_CH];
   assign win_s = sync_bus[3*N_CH-1:2*N_CH];
   assign uv_s  = sync_bus[BUS_W-1];

   pg_sup_qual #(.N_CH(N_CH)) u_qual (
      .en(en_s), .ss(ss_s), .win(win_s), .uv(uv_s), .ok(ok), .drop(drop)
   );

   pg_sup_dly #(.DELAY(DELAY)) u_dly (
      .clk(clk), .rst_n(rst_n), .ok(ok), .ready(ready)
   );

   // rise only through the qualified delay, fall without any delay
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pgood_q <= 1'b0;
      else if (pgood_q) pgood_q <= ~drop;
      else              pgood_q <= ready;
   end

   assign pgood = pgood_q;

   AST_PG_RISE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgood_q) |-> $past(ok));                    // R2
   AST_PG_UV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      uv_s |=> !pgood_q);                               // R6
   AST_PG_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !(|en_s) |=> !pgood_q);                           // R1

   generate
      for (genvar i = 0; i < N_CH; i++) begin : g_chk
         AST_PG_WIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (en_s[i] && ss_s[i] && !win_s[i]) |=> !pgood_q); // R5
      end
   endgenerate
endmodule

// File: tb/pgood_supervisor_tb_top.sv
`timescale 1ns/1ps
module pgood_supervisor_tb_top;
   localparam int D  = 2048;
   localparam int RL = D + 2;   // rise latency in edges
   localparam int DL = 3;       // fall latency in edges

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] ch_en, ch_ss_done, ch_in_win;
   logic       supply_uv;
   logic       pgood;

   int n_run  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   typedef struct {
      int    cyc;
      bit    val;
      string req;
   } exp_t;
   exp_t q[$];

   always #5 clk = ~clk;

   pgood_supervisor #(.N_CH(2), .DELAY(D), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_ss_done(ch_ss_done),
      .ch_in_win(ch_in_win), .supply_uv(supply_uv), .pgood(pgood)
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // monitor: compare queued expectations on falling edges
   always @(negedge clk) begin
      if (rst_n) begin
         while (q.size() != 0 && q[0].cyc <= cyc) begin
            exp_t it;
            it = q.pop_front();
            n_run++;
            if (it.cyc < cyc) begin
               n_fail++;
               $display("FAIL %s: check for cycle %0d missed, actual cycle=%0d expected cycle=%0d",
                        it.req, it.cyc, cyc, it.cyc);
            end else if (pgood !== it.val) begin
               n_fail++;
               $display("FAIL %s: cycle %0d pgood actual=%0b expected=%0b",
                        it.req, cyc, pgood, it.val);
            end
         end
      end
   end

   task automatic drv(input logic [1:0] e, input logic [1:0] s,
                      input logic [1:0] w, input logic u);
      @(negedge clk);
      ch_en = e; ch_ss_done = s; ch_in_win = w; supply_uv = u;
   endtask

   task automatic exp_rel(input int d, input bit v, input string r);
      q.push_back('{cyc + d, v, r});
   endtask

   task automatic exp_abs(input int c, input bit v, input string r);
      q.push_back('{c, v, r});
   endtask

   task automatic settle();
      while (q.size() != 0) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(1_500_000ns);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog (R1..R11 run): actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      int n0, n1;
      rst_n = 1'b0;
      ch_en = 2'b00; ch_ss_done = 2'b00; ch_in_win = 2'b00; supply_uv = 1'b0;
      repeat (4) @(negedge clk);
      n_run++;
      if (pgood !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: pgood in reset actual=%0b expected=0", pgood);
      end
      rst_n = 1'b1;
      exp_rel(1, 0, "R1"); exp_rel(6, 0, "R1");
      settle();

      // R3: both enabled and in window, soft-start not finished
      drv(2'b11, 2'b00, 2'b11, 1'b0);
      exp_rel(D + 5, 0, "R3");
      settle();

      // R2: soft-start done on both -> rise after the full delay
      drv(2'b11, 2'b11, 2'b11, 1'b0);
      exp_rel(RL - 1, 0, "R2"); exp_rel(RL, 1, "R2");
      settle();

      // R11: stays high well beyond twice the delay
      exp_rel(2 * D + 10, 1, "R11");
      settle();

      // R5: channel 0 leaves its window
      drv(2'b11, 2'b11, 2'b10, 1'b0);
      exp_rel(DL - 1, 1, "R5"); exp_rel(DL, 0, "R5");
      settle();
      drv(2'b11, 2'b11, 2'b11, 1'b0);
      exp_rel(RL - 1, 0, "R5"); exp_rel(RL, 1, "R5");
      settle();

      // R6: undervoltage
      drv(2'b11, 2'b11, 2'b11, 1'b1);
      exp_rel(DL - 1, 1, "R6"); exp_rel(DL, 0, "R6");
      settle();

      // R4: one-cycle window loss mid-count restarts the count
      drv(2'b11, 2'b11, 2'b11, 1'b0);
      n0 = cyc;
      exp_rel(D / 2, 0, "R4");
      settle();
      drv(2'b11, 2'b11, 2'b01, 1'b0);
      drv(2'b11, 2'b11, 2'b11, 1'b0);
      n1 = cyc;
      exp_abs(n0 + RL, 0, "R4");
      exp_abs(n1 + RL - 1, 0, "R4"); exp_abs(n1 + RL, 1, "R4");
      settle();

      // R7: disable channel 1 while high, then its flags go bad
      drv(2'b01, 2'b11, 2'b11, 1'b0);
      exp_rel(DL, 1, "R7"); exp_rel(20, 1, "R7");
      settle();
      drv(2'b01, 2'b01, 2'b01, 1'b0);
      exp_rel(DL, 1, "R7"); exp_rel(20, 1, "R7");
      settle();

      // R8: only channel 0 governs now
      drv(2'b01, 2'b01, 2'b00, 1'b0);
      exp_rel(DL - 1, 1, "R8"); exp_rel(DL, 0, "R8");
      settle();
      drv(2'b01, 2'b01, 2'b01, 1'b0);
      exp_rel(RL - 1, 0, "R8"); exp_rel(RL, 1, "R8");
      settle();

      // R9: late enable while high, ignored until its ramp is done
      drv(2'b11, 2'b01, 2'b01, 1'b0);
      exp_rel(DL, 1, "R9"); exp_rel(50, 1, "R9");
      settle();
      drv(2'b11, 2'b11, 2'b01, 1'b0);
      exp_rel(DL - 1, 1, "R9"); exp_rel(DL, 0, "R9");
      settle();
      drv(2'b11, 2'b11, 2'b11, 1'b0);
      exp_rel(RL - 1, 0, "R9"); exp_rel(RL, 1, "R9");
      settle();

      // R10: late enable during the count
      drv(2'b01, 2'b01, 2'b11, 1'b0);
      exp_rel(DL, 1, "R7");
      settle();
      drv(2'b01, 2'b01, 2'b11, 1'b1);
      exp_rel(DL, 0, "R6");
      settle();
      drv(2'b01, 2'b01, 2'b11, 1'b0);
      n0 = cyc;
      exp_rel(D / 2, 0, "R10");
      settle();
      drv(2'b11, 2'b01, 2'b11, 1'b0);
      exp_abs(n0 + RL, 0, "R10");
      exp_rel(D + 20, 0, "R10");
      settle();
      drv(2'b11, 2'b11, 2'b11, 1'b0);
      exp_rel(RL - 1, 0, "R10"); exp_rel(RL, 1, "R10");
      settle();

      // R1: both enables low
      drv(2'b00, 2'b11, 2'b11, 1'b0);
      exp_rel(DL - 1, 1, "R1"); exp_rel(DL, 0, "R1");
      exp_rel(D + 10, 0, "R1");
      settle();

      repeat (2) @(negedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule